// File: doc/BRIEF.md
# Coin-Operated Candy Dispenser Controller

This block is the control core of a candy dispenser that takes two kinds of coin: a nickel worth 5 cents and a dime worth 10 cents. A coin sensor drives one line for each coin type. The sensor is not synchronous to the controller clock, and a line may stay high for any number of cycles while a coin passes. The block brings each line into the clock domain through a chain of flip-flops. It then reduces every rising edge on the line to a pulse exactly one clock long.

The pulses feed a five-state Moore machine that tracks the credit deposited. The states are no credit, 5 cents, 10 cents, and two dispense states. When the credit reaches 15 cents the machine enters a dispense state and raises the `vend` output for one cycle, which releases one candy. No change is ever returned. If a dime brings the total to 20 cents, the machine still releases one candy and keeps the extra 5 cents as credit toward the next purchase. A parameter selects a binary or a one-hot encoding of the state register; both encodings behave the same at the ports.

Top module: `candy_vend_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts the machine in the no-credit state, and `vend` is low in every cycle after a clock edge at which `rst` is high. Credit built up before a reset is lost.
- R2: Each sense line is sampled through `SYNC_STAGES` flip-flops (at least 2) and then goes to a rising-edge detector. A line that stays high for any number of cycles yields exactly one internal coin pulse, one clock wide.
- R3: A sense line first sampled high at clock edge N that completes a purchase makes `vend` high from edge N+`SYNC_STAGES` until the next edge. With the default of 2 stages, that is edge N+2.
- R4: Coin values are 5 cents for a nickel and 10 cents for a dime. Credit of exactly 15 cents gives one `vend` pulse and leaves zero credit.
- R5: A dime added to 10 cents of credit gives one `vend` pulse and leaves 5 cents of credit, so a further dime alone completes the next purchase.
- R6: `vend` is never high for two cycles in a row. Each candy gives exactly one high cycle.
- R7: From a dispense state, the next clock edge with no coin pulse moves to the matching credit state: no credit after an exact purchase, 5 cents after an overpayment.
- R8: Credit below 15 cents never raises `vend`.
- R9: Nickel and dime pulses are never active together. The user must keep the two sense lines from rising within the same synchronizer window, and must present no coin while a dispense state is active. The machine ignores a coin pulse that arrives in a dispense state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| nickel_sense | input | 1 | Asynchronous sense line for a nickel |
| dime_sense | input | 1 | Asynchronous sense line for a dime |
| vend | output | 1 | One-cycle candy release strobe (Moore output) |

## Verification
A coin whose sense line is raised just before a clock edge reaches the state register two edges later. A purchase that the coin completes therefore shows `vend` high in the cycle that follows the third edge, counting the first edge that samples the line. Each coin task raises its line at a falling edge and samples `vend` on the falling edges that follow. It requires `vend` high on exactly the third of those edges and low on the fourth. It also counts every high cycle in a window that outlasts the hold time by six cycles. That window catches a held line that gives a second pulse, and a dispense that comes early or late.

// File: rtl/candy_vend_pkg.sv
package candy_vend_pkg;

   // Logical credit states; the order is shared by both encodings.
   typedef enum logic [2:0] {
      CR_ZERO      = 3'd0,
      CR_FIVE      = 3'd1,
      CR_TEN       = 3'd2,
      CR_VEND_ZERO = 3'd3,
      CR_VEND_FIVE = 3'd4
   } credit_e;

   localparam int unsigned CREDIT_STATES = 5;

   // Next-state rule used by the binary encoding.
   // Coin pulses seen in a dispense state are ignored.
   function automatic credit_e credit_next(input credit_e cur,
                                           input logic    nick,
                                           input logic    dime);
      credit_e nxt;
      nxt = cur;
      unique case (cur)
         CR_ZERO: begin
            if (nick)      nxt = CR_FIVE;
            else if (dime) nxt = CR_TEN;
         end
         CR_FIVE: begin
            if (nick)      nxt = CR_TEN;
            else if (dime) nxt = CR_VEND_ZERO;
         end
         CR_TEN: begin
            if (nick)      nxt = CR_VEND_ZERO;
            else if (dime) nxt = CR_VEND_FIVE;
         end
         CR_VEND_ZERO: nxt = CR_ZERO;
         CR_VEND_FIVE: nxt = CR_FIVE;
         default:      nxt = CR_ZERO;
      endcase
      return nxt;
   endfunction

endpackage

// File: rtl/candy_coin_sync.sv
module candy_coin_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic sense_raw,
   output logic coin_pulse
);

   localparam int unsigned LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_depth
      $error("candy_coin_sync: SYNC_STAGES must be at least 2");
   end

   logic [LAST:0] chain_q;
   logic          prev_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[LAST-1:0], sense_raw};
         prev_q  <= chain_q[LAST];
      end
   end

   // Rising edge of the synchronized level.
   assign coin_pulse = chain_q[LAST] & ~prev_q;

endmodule

// File: rtl/candy_credit_fsm.sv
module candy_credit_fsm
   import candy_vend_pkg::*;
#(
   parameter bit ONE_HOT = 1'b0
) (
   input  logic    clk,
   input  logic    rst,
   input  logic    nick,
   input  logic    dime,
   output credit_e credit,
   output logic    vend
);

   if (ONE_HOT) begin : g_onehot
      localparam int unsigned B_ZERO = 0;
      localparam int unsigned B_FIVE = 1;
      localparam int unsigned B_TEN  = 2;
      localparam int unsigned B_VZ   = 3;
      localparam int unsigned B_VF   = 4;

      logic [CREDIT_STATES-1:0] hot_q;
      logic [CREDIT_STATES-1:0] hot_d;
      logic                     idle_in;

      assign idle_in = ~nick & ~dime;

      always_comb begin
         hot_d[B_ZERO] = (hot_q[B_ZERO] & idle_in) | hot_q[B_VZ];
         hot_d[B_FIVE] = (hot_q[B_ZERO] & nick) | (hot_q[B_FIVE] & idle_in)
                       | hot_q[B_VF];
         hot_d[B_TEN]  = (hot_q[B_ZERO] & dime) | (hot_q[B_FIVE] & nick)
                       | (hot_q[B_TEN] & idle_in);
         hot_d[B_VZ]   = (hot_q[B_FIVE] & dime) | (hot_q[B_TEN] & nick);
         hot_d[B_VF]   = hot_q[B_TEN] & dime;
      end

      always_ff @(posedge clk) begin
         if (rst) hot_q <= CREDIT_STATES'(1) << B_ZERO;
         else     hot_q <= hot_d;
      end

      always_comb begin
         if      (hot_q[B_VF])   credit = CR_VEND_FIVE;
         else if (hot_q[B_VZ])   credit = CR_VEND_ZERO;
         else if (hot_q[B_TEN])  credit = CR_TEN;
         else if (hot_q[B_FIVE]) credit = CR_FIVE;
         else                    credit = CR_ZERO;
      end

      assign vend = hot_q[B_VZ] | hot_q[B_VF];
   end else begin : g_binary
      credit_e state_q;

      always_ff @(posedge clk) begin
         if (rst) state_q <= CR_ZERO;
         else     state_q <= credit_next(state_q, nick, dime);
      end

      assign credit = state_q;
      assign vend   = (state_q == CR_VEND_ZERO) || (state_q == CR_VEND_FIVE);
   end

endmodule

// File: rtl/candy_vend_ctrl.sv
module candy_vend_ctrl
   import candy_vend_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          ONE_HOT     = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic nickel_sense,
   input  logic dime_sense,
   output logic vend
);

   logic    nickel_pulse;
   logic    dime_pulse;
   credit_e credit_now;

   candy_coin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync_nickel (
      .clk        (clk),
      .rst        (rst),
      .sense_raw  (nickel_sense),
      .coin_pulse (nickel_pulse)
   );

   candy_coin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync_dime (
      .clk        (clk),
      .rst        (rst),
      .sense_raw  (dime_sense),
      .coin_pulse (dime_pulse)
   );

   candy_credit_fsm #(.ONE_HOT(ONE_HOT)) u_fsm (
      .clk    (clk),
      .rst    (rst),
      .nick   (nickel_pulse),
      .dime   (dime_pulse),
      .credit (credit_now),
      .vend   (vend)
   );

endmodule

// File: rtl/candy_vend_chk.sv
module candy_vend_chk
   import candy_vend_pkg::*;
(
   input logic    clk,
   input logic    rst,
   input logic    nickel_pulse,
   input logic    dime_pulse,
   input logic    vend,
   input credit_e credit
);

   // R1
   reset_quiet_chk: assert property (@(posedge clk) rst |=> !vend);

   // R6
   vend_single_chk: assert property (@(posedge clk) disable iff (rst)
      vend |=> !vend);

   // R2
   nickel_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      nickel_pulse |=> !nickel_pulse);

   // R2
   dime_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      dime_pulse |=> !dime_pulse);

   // R9
   coin_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(nickel_pulse && dime_pulse));

   // R8
   vend_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(vend) |-> $past(nickel_pulse || dime_pulse));

   // R7
   carry_return_chk: assert property (@(posedge clk) disable iff (rst)
      (credit == CR_VEND_FIVE && !nickel_pulse && !dime_pulse)
      |=> credit == CR_FIVE);

   // R7
   zero_return_chk: assert property (@(posedge clk) disable iff (rst)
      (credit == CR_VEND_ZERO && !nickel_pulse && !dime_pulse)
      |=> credit == CR_ZERO);

   // R5
   overpay_chk: assert property (@(posedge clk) disable iff (rst)
      (credit == CR_TEN && dime_pulse) |=> credit == CR_VEND_FIVE);

endmodule

bind candy_vend_ctrl candy_vend_chk u_chk (
   .clk          (clk),
   .rst          (rst),
   .nickel_pulse (nickel_pulse),
   .dime_pulse   (dime_pulse),
   .vend         (vend),
   .credit       (credit_now)
);

// File: tb/candy_vend_ctrl_bench.sv
`timescale 1ns/1ps
module candy_vend_ctrl_bench;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic nickel_sense = 1'b0;
   logic dime_sense = 1'b0;
   logic vend;
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   always #4 clk = ~clk;

   candy_vend_ctrl u_candy_vend_ctrl (
      .clk          (clk),
      .rst          (rst),
      .nickel_sense (nickel_sense),
      .dime_sense   (dime_sense),
      .vend         (vend)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Raise one sense line for hold cycles; vend is due on the third falling edge.
   task automatic coin(input bit is_dime, input int hold, input bit exp, input string req);
      int seen = 0;
      @(negedge clk);
      if (is_dime) dime_sense = 1'b1; else nickel_sense = 1'b1;
      for (int k = 1; k <= hold + 6; k++) begin
         @(negedge clk);
         if (vend) seen++;
         if (k == 3) check(vend == exp, {req, " R3 vend timing"}, vend, exp);
         if (k == 4) check(vend == 1'b0, {req, " R6 vend width"}, vend, 0);
         if (k == hold) begin
            nickel_sense = 1'b0;
            dime_sense   = 1'b0;
         end
      end
      check(seen == int'(exp), {req, " R2 vend count"}, seen, exp);
   endtask

   task automatic t_three_nickels();
      coin(1'b0, 1, 1'b0, "R8 5c");
      coin(1'b0, 2, 1'b0, "R8 10c");
      coin(1'b0, 1, 1'b1, "R4 15c");
   endtask

   task automatic t_mixed_orders();
      coin(1'b0, 1, 1'b0, "R8 nickel first");
      coin(1'b1, 1, 1'b1, "R4 nickel+dime");
      coin(1'b1, 3, 1'b0, "R8 dime first");
      coin(1'b0, 1, 1'b1, "R4 dime+nickel");
   endtask

   task automatic t_overpay_carry();
      coin(1'b1, 1, 1'b0, "R8 first dime");
      coin(1'b1, 1, 1'b1, "R5 20c vends");
      coin(1'b1, 1, 1'b1, "R5 carry+dime vends");
      coin(1'b1, 1, 1'b0, "R7 credit zero after exact");
      coin(1'b1, 1, 1'b1, "R5 second overpay");
      coin(1'b0, 1, 1'b0, "R7 carry+nickel 10c");
      coin(1'b0, 1, 1'b1, "R7 carry+2 nickels");
   endtask

   task automatic t_long_hold();
      coin(1'b0, 20, 1'b0, "R2 long nickel");
      coin(1'b0, 15, 1'b0, "R2 long nickel 2");
      coin(1'b0, 9, 1'b1, "R2 held third nickel");
   endtask

   task automatic t_reset_midway();
      coin(1'b1, 1, 1'b0, "R8 dime before reset");
      @(negedge clk); rst = 1'b1;
      @(negedge clk);
      check(vend == 1'b0, "R1 vend during reset", vend, 0);
      rst = 1'b0;
      coin(1'b0, 1, 1'b0, "R1 credit cleared");
      coin(1'b1, 1, 1'b1, "R1 fresh 15c");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(vend == 1'b0, "R1 reset state", vend, 0);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      check(vend == 1'b0, "R1 idle after reset", vend, 0);
      t_three_nickels();
      t_mixed_orders();
      t_overpay_carry();
      t_long_hold();
      t_reset_midway();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule